// File: doc/BRIEF.md
# DMA Channel Programming Sequencer

This block lets host-side logic set up one channel of a byte-wide DMA controller that is driven through two I/O ports: a command port and an execute port, which carries data. A single start pulse supplies the channel number, a 24-bit physical address, a 16-bit byte count and the transfer direction. The sequencer then issues the eleven byte writes the controller needs, in a fixed order. It masks the channel first. It loads the address and the count. It sets the transfer mode and unmasks the channel last. Each write goes out on a one-write-per-cycle bus that the receiver paces with a ready input.

Inside, a three-state machine (ST_IDLE, ST_ISSUE, ST_DONE) steps through a table that works out the port and the byte of every write from the captured inputs. The transitions are as follows. ST_IDLE goes to ST_ISSUE on start, and the inputs are captured at that moment. ST_ISSUE stays in ST_ISSUE while each write is accepted, until the final write. ST_ISSUE goes to ST_DONE when the final write is accepted. ST_DONE returns to ST_IDLE after one cycle.

Top module: `dma_chan_prog_seq`

## Requirements
- R1: After reset the block is idle: wr_valid_o, busy_o and done_o are all low.
- R2: A start_i sampled high while idle captures the inputs. From the next cycle the first write is presented: command port (wr_port_o = 0) with byte 0x90 plus the channel.
- R3: The second write is byte 0x20 plus the channel to the command port, which masks the channel.
- R4: The next three writes go to the execute port (wr_port_o = 1). They carry address bits 7:0, then 15:8, then 23:16.
- R5: Then comes 0x40 plus the channel on the command port. After it the execute port receives the byte count minus one, bits 7:0 then bits 15:8. A count of zero wraps to 0xFFFF.
- R6: Then comes 0x70 plus the channel on the command port, followed by the mode byte on the execute port. The mode byte is 0x4C when is_read_i is 1 (device to memory) and 0x44 when it is 0.
- R7: The eleventh write is 0xA0 plus the channel on the command port. done_o is high for exactly the one cycle after that write is accepted, and the block is idle in the cycle after that.
- R8: A write is accepted on a clock edge where wr_valid_o and wr_ready_i are both high. Until then wr_valid_o stays high and wr_port_o and wr_data_o hold their values.
- R9: A start_i that arrives while busy_o is high is ignored, including in the done cycle. The running sequence and its byte values are unchanged.
- R10: Changes on chan_i, addr_i, count_i and is_read_i after the start is accepted do not alter any write of the running sequence.
- R11: wr_ready_i has no effect while the block is idle: no write appears and done_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to program a channel |
| chan_i | input | 3 | DMA channel number |
| addr_i | input | 24 | Physical start address |
| count_i | input | 16 | Transfer length in bytes |
| is_read_i | input | 1 | 1 = device to memory, 0 = memory to device |
| wr_valid_o | output | 1 | A port write is presented |
| wr_port_o | output | 1 | 0 = command port, 1 = execute port |
| wr_data_o | output | 8 | Byte to write |
| wr_ready_i | input | 1 | Receiver accepts the presented write |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse after the final write |

## Verification
Several properties are checked on every cycle:
- A presented write stays stable until it is accepted.
- done_o is a single-cycle pulse that follows an accepted command-port write.
- The first write of each sequence is the 0x90-based command.
- The captured channel, address, count and direction do not move while busy.
- Nothing is presented in idle without a start.

The full byte order, the offsets on the command bytes, the split of address and count into bytes, the count-minus-one wrap at zero, and the mode byte for each direction can only be shown by the directed scenarios. Those scenarios also show that start pulses and input changes during a run are ignored, under several ready-stall patterns.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_e;

    // command-port opcodes; the channel number is added to each
    localparam logic [7:0] OP_PREP    = 8'h90;
    localparam logic [7:0] OP_MASK    = 8'h20;
    localparam logic [7:0] OP_CNT_SEL = 8'h40;
    localparam logic [7:0] OP_MOD_SEL = 8'h70;
    localparam logic [7:0] OP_UNMASK  = 8'hA0;

    // mode bytes for the execute port
    localparam logic [7:0] MODE_DEV2MEM = 8'h4C;
    localparam logic [7:0] MODE_MEM2DEV = 8'h44;

    localparam logic PORT_CMD = 1'b0;
    localparam logic PORT_EXE = 1'b1;

endpackage

// File: rtl/dmaseq_capture.sv
module dmaseq_capture #(
    parameter int CHAN_W = 3,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              is_read_i,
    output logic [CHAN_W-1:0] chan_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cntm1_q,
    output logic              rd_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q  <= '0;
            addr_q  <= '0;
            cntm1_q <= '0;
            rd_q    <= 1'b0;
        end else if (load_i) begin
            chan_q  <= chan_i;
            addr_q  <= addr_i;
            cntm1_q <= count_i - ONE;  // zero wraps to all ones
            rd_q    <= is_read_i;
        end
    end

endmodule

// File: rtl/dmaseq_step_rom.sv
module dmaseq_step_rom
    import dmaseq_pkg::*;
#(
    parameter int CHAN_W     = 3,
    parameter int ADDR_BYTES = 3,
    parameter int CNT_BYTES  = 2,
    parameter int STEP_W     = 4
) (
    input  logic [STEP_W-1:0]       step_i,
    input  logic [CHAN_W-1:0]       chan_i,
    input  logic [8*ADDR_BYTES-1:0] addr_i,
    input  logic [8*CNT_BYTES-1:0]  cntm1_i,
    input  logic                    rd_i,
    output logic                    port_o,
    output logic [7:0]              data_o,
    output logic                    last_o
);

    localparam int S_PREP    = 0;
    localparam int S_MASK    = 1;
    localparam int S_ADDR0   = 2;
    localparam int S_CNTSEL  = S_ADDR0 + ADDR_BYTES;
    localparam int S_CNT0    = S_CNTSEL + 1;
    localparam int S_MODSEL  = S_CNT0 + CNT_BYTES;
    localparam int S_MODE    = S_MODSEL + 1;
    localparam int S_UNMASK  = S_MODE + 1;

    logic [7:0] addr_b [ADDR_BYTES];
    logic [7:0] cnt_b  [CNT_BYTES];
    logic [7:0] ch8;

    genvar gi;
    generate
        for (gi = 0; gi < ADDR_BYTES; gi++) begin : g_abyte
            assign addr_b[gi] = addr_i[8*gi +: 8];
        end
        for (gi = 0; gi < CNT_BYTES; gi++) begin : g_cbyte
            assign cnt_b[gi] = cntm1_i[8*gi +: 8];
        end
    endgenerate

    assign ch8 = {{(8-CHAN_W){1'b0}}, chan_i};

    always_comb begin
        int s;
        s      = int'(step_i);
        port_o = PORT_CMD;
        data_o = 8'h00;
        last_o = 1'b0;
        if (s == S_PREP) begin
            data_o = OP_PREP + ch8;
        end else if (s == S_MASK) begin
            data_o = OP_MASK + ch8;
        end else if (s >= S_ADDR0 && s < S_CNTSEL) begin
            port_o = PORT_EXE;
            data_o = addr_b[s - S_ADDR0];
        end else if (s == S_CNTSEL) begin
            data_o = OP_CNT_SEL + ch8;
        end else if (s >= S_CNT0 && s < S_MODSEL) begin
            port_o = PORT_EXE;
            data_o = cnt_b[s - S_CNT0];
        end else if (s == S_MODSEL) begin
            data_o = OP_MOD_SEL + ch8;
        end else if (s == S_MODE) begin
            port_o = PORT_EXE;
            data_o = rd_i ? MODE_DEV2MEM : MODE_MEM2DEV;
        end else if (s == S_UNMASK) begin
            data_o = OP_UNMASK + ch8;
            last_o = 1'b1;
        end
    end

endmodule

// File: rtl/dma_chan_prog_seq.sv
module dma_chan_prog_seq
    import dmaseq_pkg::*;
#(
    parameter int CHAN_W     = 3,
    parameter int ADDR_BYTES = 3,
    parameter int CNT_BYTES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [CHAN_W-1:0]       chan_i,
    input  logic [8*ADDR_BYTES-1:0] addr_i,
    input  logic [8*CNT_BYTES-1:0]  count_i,
    input  logic                    is_read_i,
    output logic                    wr_valid_o,
    output logic                    wr_port_o,
    output logic [7:0]              wr_data_o,
    input  logic                    wr_ready_i,
    output logic                    busy_o,
    output logic                    done_o
);

    localparam int ADDR_W  = 8 * ADDR_BYTES;
    localparam int CNT_W   = 8 * CNT_BYTES;
    localparam int N_STEPS = 6 + ADDR_BYTES + CNT_BYTES;
    localparam int STEP_W  = $clog2(N_STEPS + 1);

    seq_state_e        state_q, state_d;
    logic [STEP_W-1:0] step_q;
    logic              accept;
    logic              take;
    logic              last;
    logic              rom_port;
    logic [7:0]        rom_data;
    logic [CHAN_W-1:0] chan_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cntm1_q;
    logic              rd_q;

    assign accept = (state_q == ST_IDLE) && start_i;
    assign take   = (state_q == ST_ISSUE) && wr_ready_i;

    dmaseq_capture #(
        .CHAN_W (CHAN_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .chan_i    (chan_i),
        .addr_i    (addr_i),
        .count_i   (count_i),
        .is_read_i (is_read_i),
        .chan_q    (chan_q),
        .addr_q    (addr_q),
        .cntm1_q   (cntm1_q),
        .rd_q      (rd_q)
    );

    dmaseq_step_rom #(
        .CHAN_W     (CHAN_W),
        .ADDR_BYTES (ADDR_BYTES),
        .CNT_BYTES  (CNT_BYTES),
        .STEP_W     (STEP_W)
    ) u_rom (
        .step_i  (step_q),
        .chan_i  (chan_q),
        .addr_i  (addr_q),
        .cntm1_i (cntm1_q),
        .rd_i    (rd_q),
        .port_o  (rom_port),
        .data_o  (rom_data),
        .last_o  (last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)      state_d = ST_ISSUE;
            ST_ISSUE: if (take && last) state_d = ST_DONE;
            ST_DONE:                    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // state register and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                step_q <= '0;
            else if (take && !last)
                step_q <= step_q + STEP_W'(1);
        end
    end

    // outputs
    always_comb begin
        wr_valid_o = 1'b0;
        wr_port_o  = PORT_CMD;
        wr_data_o  = 8'h00;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_ISSUE: begin
                wr_valid_o = 1'b1;
                wr_port_o  = rom_port;
                wr_data_o  = rom_data;
            end
            ST_DONE: done_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    // R8: a stalled write holds its port and byte
    a_r8_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=>
            (wr_valid_o && $stable(wr_port_o) && $stable(wr_data_o)));

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    // R7: done follows an accepted command-port write
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(wr_valid_o && wr_ready_i && (wr_port_o == PORT_CMD)));

    // R2: each sequence opens with the prepare command
    a_r2_first_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid_o) |->
            (wr_port_o == PORT_CMD) && (wr_data_o == OP_PREP + {{(8-CHAN_W){1'b0}}, chan_q}));

    // R9 and R10: captured settings do not move while busy
    a_r9_r10_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |->
            ($stable(chan_q) && $stable(addr_q) && $stable(cntm1_q) && $stable(rd_q)));

    // R11: idle without start produces no write
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> (!wr_valid_o && !done_o));

endmodule

// File: tb/dma_chan_prog_seq_tb.sv
module dma_chan_prog_seq_tb;

    localparam int NW = 11;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [2:0]  chan_i;
    logic [23:0] addr_i;
    logic [15:0] count_i;
    logic        is_read_i;
    logic        wr_valid_o;
    logic        wr_port_o;
    logic [7:0]  wr_data_o;
    logic        wr_ready_i;
    logic        busy_o;
    logic        done_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    dma_chan_prog_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .chan_i     (chan_i),
        .addr_i     (addr_i),
        .count_i    (count_i),
        .is_read_i  (is_read_i),
        .wr_valid_o (wr_valid_o),
        .wr_port_o  (wr_port_o),
        .wr_data_o  (wr_data_o),
        .wr_ready_i (wr_ready_i),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_w(input int k, input logic [2:0] ch,
                                         input logic [23:0] a, input logic [15:0] c,
                                         input logic rd);
        logic [15:0] m;
        logic [7:0]  c8;
        m  = c - 16'd1;
        c8 = {5'd0, ch};
        case (k)
            0:  return {1'b0, 8'h90 + c8};
            1:  return {1'b0, 8'h20 + c8};
            2:  return {1'b1, a[7:0]};
            3:  return {1'b1, a[15:8]};
            4:  return {1'b1, a[23:16]};
            5:  return {1'b0, 8'h40 + c8};
            6:  return {1'b1, m[7:0]};
            7:  return {1'b1, m[15:8]};
            8:  return {1'b0, 8'h70 + c8};
            9:  return {1'b1, rd ? 8'h4C : 8'h44};
            default: return {1'b0, 8'hA0 + c8};
        endcase
    endfunction

    function automatic string req_of(input int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2, 3, 4: return "R4";
            5, 6, 7: return "R5";
            8, 9: return "R6";
            default: return "R7";
        endcase
    endfunction

    // One full sequence. stall: 0 = always ready, else ready every stall-th cycle.
    // disturb: pulse start and change inputs while busy (R9, R10).
    task automatic run_seq(input logic [2:0] ch, input logic [23:0] a,
                           input logic [15:0] c, input logic rd,
                           input int stall, input logic disturb);
        int         k;
        int         cyc;
        logic       prev_wait;
        logic [8:0] prev_w;
        logic       rdy;
        @(negedge clk);
        start_i = 1'b1; chan_i = ch; addr_i = a; count_i = c; is_read_i = rd;
        wr_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        k = 0; cyc = 0; prev_wait = 1'b0; prev_w = '0;
        while (k < NW && cyc < 200) begin
            if (prev_wait)
                chk(wr_valid_o && {wr_port_o, wr_data_o} == prev_w, "R8 hold",
                    {23'd0, wr_port_o, wr_data_o}, {23'd0, prev_w});
            rdy = (stall == 0) || ((cyc % stall) == stall - 1);
            if (wr_valid_o && rdy)
                chk({wr_port_o, wr_data_o} == exp_w(k, ch, a, c, rd), req_of(k),
                    {23'd0, wr_port_o, wr_data_o}, {23'd0, exp_w(k, ch, a, c, rd)});
            if (!wr_valid_o)
                chk(1'b0, "R8 valid dropped", 32'd0, 32'd1);
            prev_wait = wr_valid_o && !rdy;
            prev_w    = {wr_port_o, wr_data_o};
            if (wr_valid_o && rdy) k++;
            wr_ready_i = rdy;
            if (disturb && cyc == 2) start_i = 1'b1;
            else start_i = 1'b0;
            if (disturb && cyc >= 1) begin
                chan_i = ~ch; addr_i = ~a; count_i = c ^ 16'h5A5A; is_read_i = ~rd;
            end
            cyc++;
            @(negedge clk);
        end
        // done cycle
        chk(done_o && !wr_valid_o, "R7 done pulse", {31'd0, done_o}, 32'd1);
        wr_ready_i = 1'b0;
        start_i = disturb;  // start during done cycle must be ignored (R9)
        @(negedge clk);
        start_i = 1'b0;
        chk(!done_o && !busy_o && !wr_valid_o, "R7 idle after done",
            {29'd0, done_o, busy_o, wr_valid_o}, 32'd0);
        @(negedge clk);
        chk(!busy_o && !wr_valid_o, "R9 no restart", {30'd0, busy_o, wr_valid_o}, 32'd0);
    endtask

    task automatic t_reset;
        chk(!wr_valid_o && !busy_o && !done_o, "R1 reset",
            {29'd0, wr_valid_o, busy_o, done_o}, 32'd0);
    endtask

    task automatic t_idle_ready;
        @(negedge clk);
        wr_ready_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!wr_valid_o && !done_o && !busy_o, "R11 ready in idle",
                {29'd0, wr_valid_o, done_o, busy_o}, 32'd0);
        end
        wr_ready_i = 1'b0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; chan_i = '0; addr_i = '0; count_i = '0;
        is_read_i = 1'b0; wr_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ready();
        run_seq(3'd5, 24'h123456, 16'h0200, 1'b1, 0, 1'b0);   // R2-R7 read
        run_seq(3'd1, 24'hABCDEF, 16'h0001, 1'b0, 3, 1'b0);   // R6 write, R8 stalls
        run_seq(3'd7, 24'hFF0080, 16'h0000, 1'b1, 2, 1'b0);   // R5 count wrap
        run_seq(3'd0, 24'h00FF00, 16'h1234, 1'b0, 0, 1'b1);   // R9, R10
        run_seq(3'd6, 24'h800001, 16'hFFFF, 1'b1, 4, 1'b1);   // R9, R10 with stalls
        t_idle_ready();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule